// File: doc/BRIEF.md
# PCM Time-Slot Window Assigner

This block produces the bit-level receive and transmit enable strobes for one serial channel that sits on a time-slot PCM bus. Both directions run from a single externally supplied bit clock, and both are timed from a frame sync input. A shared offset counter numbers the clocks that follow each frame sync. Each direction then decodes that count against its own configuration to decide whether its window is open.

Each direction can use one of two windowing modes. In single mode there is one window, with a start position and a width that are both programmable. In multi mode up to 32 byte-wide slots are selected through a 32-bit mask. The counter follows one of two policies: it can wrap every 1024 clocks, or it can halt at its maximum until the next frame sync. An optional active-low indicator shows when the transmit window is open. All configuration is presented on plain input ports.

Top module: `tsa_window_gen`

## Requirements
- R1: When `fsync` is sampled high on a rising edge, the counter loads count 1 for the next clock. The count then rises by one per clock. A start field `S` (0..1023) places the first active bit at count `S+1`, so the delay after the sync is 1..1024 clocks.
- R2: In single mode (`*_multi`=0), a width field `W` (0..511) holds the enable high for exactly `W+1` consecutive counts, starting at count `S+1`. Counts past 1024 do not exist, so a window that runs beyond count 1024 is cut short there.
- R3: In multi mode (`*_multi`=1), mask bit k (bit 0 = slot 0) enables 8 consecutive counts starting at count `S+1+8k`. Adjacent enabled slots join with no gap between them.
- R4: In multi mode, a slot whose last count would fall after count 1024 stays fully disabled, even when its mask bit is set.
- R5: The receive and transmit enables are decoded independently. Each uses its own mode, start, width and mask from the same count.
- R6: `tx_win_n` is low in exactly those clocks where `tx_en` is high and `tx_ind_en` is 1. When `tx_ind_en` is 0, `tx_win_n` stays high.
- R7: With `cont_mode`=1 and no further sync, the count goes from 1024 back to 1, so the windows repeat every 1024 clocks.
- R8: A frame sync that arrives before count 1024 restarts the count at 1 on the next clock.
- R9: With `cont_mode`=0, the counter halts once count 1024 has passed. Both enables then stay low until the next frame sync.
- R10: After reset, and until the first frame sync, both enables are low and `tx_win_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bit clock for both directions |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| cont_mode | input | 1 | 1: counter wraps every 1024 clocks; 0: counter halts at its maximum |
| tx_ind_en | input | 1 | Enables the active-low transmit window indicator |
| rx_multi | input | 1 | Receive mode: 0 single window, 1 byte-slot mask |
| rx_start | input | 10 | Receive start field S, first active count S+1 |
| rx_width | input | 9 | Receive single-window width field W, width W+1 |
| rx_mask | input | 32 | Receive byte-slot enable mask |
| tx_multi | input | 1 | Transmit mode: 0 single window, 1 byte-slot mask |
| tx_start | input | 10 | Transmit start field S |
| tx_width | input | 9 | Transmit single-window width field W |
| tx_mask | input | 32 | Transmit byte-slot enable mask |
| rx_en | output | 1 | Registered receive bit enable |
| tx_en | output | 1 | Registered transmit bit enable |
| tx_win_n | output | 1 | Active-low transmit window indicator |

## Verification
The bench looks for off-by-one errors at the start of the window. A design that loads 0 on sync, or registers the enable one stage late, shifts every window by one clock. It runs windows that reach count 1024, both the last-count-only case and a truncated wide window, and it runs a multi-mode slot that straddles count 1024. A design that lets that slot through would pulse past the frame end, and a design with a faulty bound would drop the slot just before it.

The bench also runs frames past count 1024 under both counter policies. A halting design that wraps would reopen its windows, and a wrapping design that halts would go silent. Finally, it sends an early sync partway through a frame. A design that ignores this sync would open its windows at the old frame's positions.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    // Offset counter states
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,   // after reset, no sync seen yet
        ST_COUNT = 2'd1,   // numbering clocks since last sync
        ST_HOLD  = 2'd2    // halted at maximum, awaiting sync
    } tsa_state_e;

    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;
    localparam int NUM_DIR = 2;

endpackage

// File: rtl/tsa_offset_ctr.sv
module tsa_offset_ctr
    import tsa_pkg::*;
#(
    parameter int CNT_MAX = 1024,
    localparam int CW = $clog2(CNT_MAX) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          cont_mode,
    output logic [CW-1:0] cnt_nxt,
    output logic          run_nxt,
    output logic [CW-1:0] cnt_q,
    output tsa_state_e    st_q
);

    localparam logic [CW-1:0] LAST = CW'(CNT_MAX);
    localparam logic [CW-1:0] ONE  = CW'(1);

    tsa_state_e st_nxt;

    // State and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Transitions: sync restart, step, wrap, stall
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (fsync) begin
            st_nxt  = ST_COUNT;
            cnt_nxt = ONE;
        end else begin
            unique case (st_q)
                ST_WAIT: begin
                    st_nxt = ST_WAIT;
                end
                ST_COUNT: begin
                    if (cnt_q == LAST) begin
                        if (cont_mode) begin
                            cnt_nxt = ONE;
                        end else begin
                            st_nxt = ST_HOLD;
                        end
                    end else begin
                        cnt_nxt = cnt_q + ONE;
                    end
                end
                ST_HOLD: begin
                    st_nxt = ST_HOLD;
                end
                default: begin
                    st_nxt  = ST_WAIT;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // Output decode: count is live only in ST_COUNT
    always_comb begin
        run_nxt = (st_nxt == ST_COUNT);
    end

endmodule

// File: rtl/tsa_window_dec.sv
module tsa_window_dec #(
    parameter int CNT_MAX   = 1024,
    parameter int WIDTH_MAX = 512,
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int CW    = $clog2(CNT_MAX) + 1,
    localparam int OFF_W = $clog2(CNT_MAX),
    localparam int WID_W = $clog2(WIDTH_MAX),
    localparam int EW    = CW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt,
    input  logic             run,
    input  logic             multi,
    input  logic [OFF_W-1:0] start,
    input  logic [WID_W-1:0] width,
    input  logic [SLOTS-1:0] mask,
    output logic             en
);

    localparam logic [EW-1:0] LAST_E = EW'(CNT_MAX);

    logic [EW-1:0]    cnt_w;
    logic [EW-1:0]    first_w;
    logic [EW-1:0]    final_w;
    logic [EW-1:0]    rel_w;
    logic             past_first;
    logic             hit_single;
    logic             hit_multi;
    logic [SLOTS-1:0] slot_hit;

    always_comb begin
        cnt_w      = EW'(cnt);
        first_w    = EW'(start) + EW'(1);
        final_w    = first_w + EW'(width);
        past_first = (cnt_w >= first_w);
        rel_w      = cnt_w - first_w;
        hit_single = past_first && (cnt_w <= final_w);
    end

    // One comparator set per byte slot
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam logic [EW-1:0] LO  = EW'(k * SLOT_BITS);
        localparam logic [EW-1:0] HI  = EW'(k * SLOT_BITS + SLOT_BITS - 1);
        logic fits;
        always_comb begin
            fits        = ((first_w + HI) <= LAST_E);
            slot_hit[k] = mask[k] && fits && (rel_w >= LO) && (rel_w <= HI);
        end
    end

    always_comb begin
        hit_multi = past_first && (|slot_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else begin
            en <= run && (multi ? hit_multi : hit_single);
        end
    end

endmodule

// File: rtl/tsa_window_gen.sv
module tsa_window_gen
    import tsa_pkg::*;
#(
    parameter int CNT_MAX   = 1024,
    parameter int WIDTH_MAX = 512,
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int CW    = $clog2(CNT_MAX) + 1,
    localparam int OFF_W = $clog2(CNT_MAX),
    localparam int WID_W = $clog2(WIDTH_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             cont_mode,
    input  logic             tx_ind_en,
    input  logic             rx_multi,
    input  logic [OFF_W-1:0] rx_start,
    input  logic [WID_W-1:0] rx_width,
    input  logic [SLOTS-1:0] rx_mask,
    input  logic             tx_multi,
    input  logic [OFF_W-1:0] tx_start,
    input  logic [WID_W-1:0] tx_width,
    input  logic [SLOTS-1:0] tx_mask,
    output logic             rx_en,
    output logic             tx_en,
    output logic             tx_win_n
);

    logic [CW-1:0]    cnt_nxt;
    logic             run_nxt;
    logic [CW-1:0]    cnt_q;
    tsa_state_e       st_q;

    logic             dir_multi [NUM_DIR];
    logic [OFF_W-1:0] dir_start [NUM_DIR];
    logic [WID_W-1:0] dir_width [NUM_DIR];
    logic [SLOTS-1:0] dir_mask  [NUM_DIR];
    logic             dir_en    [NUM_DIR];

    always_comb begin
        dir_multi[DIR_RX] = rx_multi;
        dir_start[DIR_RX] = rx_start;
        dir_width[DIR_RX] = rx_width;
        dir_mask[DIR_RX]  = rx_mask;
        dir_multi[DIR_TX] = tx_multi;
        dir_start[DIR_TX] = tx_start;
        dir_width[DIR_TX] = tx_width;
        dir_mask[DIR_TX]  = tx_mask;
    end

    tsa_offset_ctr #(
        .CNT_MAX (CNT_MAX)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .cont_mode (cont_mode),
        .cnt_nxt   (cnt_nxt),
        .run_nxt   (run_nxt),
        .cnt_q     (cnt_q),
        .st_q      (st_q)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        tsa_window_dec #(
            .CNT_MAX   (CNT_MAX),
            .WIDTH_MAX (WIDTH_MAX),
            .SLOTS     (SLOTS),
            .SLOT_BITS (SLOT_BITS)
        ) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_nxt),
            .run   (run_nxt),
            .multi (dir_multi[d]),
            .start (dir_start[d]),
            .width (dir_width[d]),
            .mask  (dir_mask[d]),
            .en    (dir_en[d])
        );
    end

    always_comb begin
        rx_en    = dir_en[DIR_RX];
        tx_en    = dir_en[DIR_TX];
        tx_win_n = ~(tx_en & tx_ind_en);
    end

endmodule

// File: rtl/tsa_window_chk.sv
module tsa_window_chk
    import tsa_pkg::*;
#(
    parameter int CNT_MAX = 1024,
    localparam int CW = $clog2(CNT_MAX) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fsync,
    input logic          cont_mode,
    input logic          tx_ind_en,
    input logic          rx_en,
    input logic          tx_en,
    input logic          tx_win_n,
    input logic [CW-1:0] cnt_q,
    input tsa_state_e    st_q
);

    localparam logic [CW-1:0] LAST = CW'(CNT_MAX);

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && !fsync && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)))
        else $error("a_r1_step");

    a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cnt_q == CW'(1) && st_q == ST_COUNT))
        else $error("a_r8_sync_restart");

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && cont_mode && !fsync && cnt_q == LAST) |=> (cnt_q == CW'(1) && st_q == ST_COUNT))
        else $error("a_r7_wrap");

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && !cont_mode && !fsync && cnt_q == LAST) |=> (st_q == ST_HOLD && !rx_en && !tx_en))
        else $error("a_r9_stall");

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_COUNT) |-> (!rx_en && !tx_en))
        else $error("a_r10_quiet");

    a_r6_low_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_win_n |-> (tx_en && tx_ind_en))
        else $error("a_r6_low_needs_tx");

    a_r6_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ind_en |-> tx_win_n)
        else $error("a_r6_off_high");

endmodule

bind tsa_window_gen tsa_window_chk #(.CNT_MAX(CNT_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .cont_mode (cont_mode),
    .tx_ind_en (tx_ind_en),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .tx_win_n  (tx_win_n),
    .cnt_q     (cnt_q),
    .st_q      (st_q)
);

// File: tb/tb_tsa_window_gen.sv
`timescale 1ns/1ps
module tb_tsa_window_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        cont_mode = 1'b0;
    logic        tx_ind_en = 1'b0;
    logic        rx_multi = 1'b0;
    logic [9:0]  rx_start = '0;
    logic [8:0]  rx_width = '0;
    logic [31:0] rx_mask = '0;
    logic        tx_multi = 1'b0;
    logic [9:0]  tx_start = '0;
    logic [8:0]  tx_width = '0;
    logic [31:0] tx_mask = '0;
    logic        rx_en;
    logic        tx_en;
    logic        tx_win_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsa_window_gen dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .cont_mode(cont_mode),
        .tx_ind_en(tx_ind_en),
        .rx_multi(rx_multi), .rx_start(rx_start), .rx_width(rx_width), .rx_mask(rx_mask),
        .tx_multi(tx_multi), .tx_start(tx_start), .tx_width(tx_width), .tx_mask(tx_mask),
        .rx_en(rx_en), .tx_en(tx_en), .tx_win_n(tx_win_n)
    );

    typedef struct packed {
        logic        rxm;
        logic [9:0]  rxs;
        logic [8:0]  rxw;
        logic [31:0] rxk;
        logic        txm;
        logic [9:0]  txs;
        logic [8:0]  txw;
        logic [31:0] txk;
        logic        cont;
        logic        ind;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'd0,   9'd0,   32'h0,         1'b0, 10'd9,    9'd15,  32'h0,         1'b0, 1'b1},
        '{1'b0, 10'd99,  9'd511, 32'h0,         1'b1, 10'd0,    9'd0,   32'h0000_0005, 1'b0, 1'b0},
        '{1'b1, 10'd3,   9'd0,   32'hFFFF_FFFF, 1'b0, 10'd1023, 9'd511, 32'h0,         1'b0, 1'b1},
        '{1'b1, 10'd999, 9'd0,   32'h0000_000C, 1'b1, 10'd0,    9'd0,   32'h8000_0001, 1'b0, 1'b1},
        '{1'b0, 10'd700, 9'd399, 32'h0,         1'b0, 10'd0,    9'd511, 32'h0,         1'b0, 1'b0},
        '{1'b0, 10'd0,   9'd0,   32'h0,         1'b1, 10'd1016, 9'd0,   32'h0000_0001, 1'b1, 1'b1}
    };

    // Expected enable at count c (0 = counter not running)
    function automatic bit exp_en(bit m, int s_f, int w_f, logic [31:0] mk, int c);
        int first;
        int k;
        first = s_f + 1;
        if (c < 1) return 1'b0;
        if (!m) return (c >= first) && (c <= first + w_f);
        if (c < first) return 1'b0;
        k = (c - first) / 8;
        if (k > 31) return 1'b0;
        return mk[k] && (first + 8 * k + 7 <= 1024);
    endfunction

    function automatic int frame_count(int i, bit cont);
        if (cont) return ((i - 1) % 1024) + 1;
        return (i <= 1024) ? i : 0;
    endfunction

    task automatic apply(vec_t v);
        rx_multi = v.rxm; rx_start = v.rxs; rx_width = v.rxw; rx_mask = v.rxk;
        tx_multi = v.txm; tx_start = v.txs; tx_width = v.txw; tx_mask = v.txk;
        cont_mode = v.cont; tx_ind_en = v.ind;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse sync at a negedge, then compare n samples (sample i = count i)
    task automatic run_frame(int n, int vi);
        bit rx_ok = 1'b1;
        bit tx_ok = 1'b1;
        bit ind_ok = 1'b1;
        int bad_at = 0;
        bit er, et, ew;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        for (int i = 1; i <= n; i++) begin
            er = exp_en(rx_multi, int'(rx_start), int'(rx_width), rx_mask, frame_count(i, cont_mode));
            et = exp_en(tx_multi, int'(tx_start), int'(tx_width), tx_mask, frame_count(i, cont_mode));
            ew = !(et && tx_ind_en);
            if (rx_ok && rx_en !== er) begin
                rx_ok = 1'b0; bad_at = i;
                $display("FAIL R1 R2 R3 R4 R7 R9 vec %0d rx sample %0d actual=%0b expected=%0b", vi, i, rx_en, er);
            end
            if (tx_ok && tx_en !== et) begin
                tx_ok = 1'b0; bad_at = i;
                $display("FAIL R1 R2 R3 R4 R5 R7 R9 vec %0d tx sample %0d actual=%0b expected=%0b", vi, i, tx_en, et);
            end
            if (ind_ok && tx_win_n !== ew) begin
                ind_ok = 1'b0; bad_at = i;
                $display("FAIL R6 vec %0d sample %0d actual=%0b expected=%0b", vi, i, tx_win_n, ew);
            end
            @(negedge clk);
        end
        checks += 3;
        failures += int'(!rx_ok) + int'(!tx_ok) + int'(!ind_ok);
        if (bad_at < 0) $display("unreachable");
    endtask

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ok_q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_ind_en = 1'b1;
        rx_width = 9'd511;
        tx_width = 9'd511;

        // R10: no sync yet, enables must stay low
        ok_q = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rx_en !== 1'b0 || tx_en !== 1'b0 || tx_win_n !== 1'b1) ok_q = 1'b0;
        end
        check(ok_q, "R10 quiet before first sync", int'(rx_en | tx_en), 0);
        check(tx_win_n === 1'b1, "R10 indicator idle", int'(tx_win_n), 1);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v]);
            run_frame(VECS[v].cont ? 1100 : 1030, v);
        end

        // R9: halted counter stays quiet long after count 1024
        apply(VECS[4]);
        run_frame(1024, 4);
        repeat (20) @(negedge clk);
        check(rx_en === 1'b0 && tx_en === 1'b0, "R9 halted until next sync", int'(rx_en | tx_en), 0);

        // R8: early sync in continuous mode restarts at count 1
        cont_mode = 1'b1; tx_ind_en = 1'b1;
        rx_multi = 1'b0; rx_start = 10'd4; rx_width = 9'd2;    // counts 5..7
        tx_multi = 1'b1; tx_start = 10'd300; tx_mask = 32'h1;  // counts 301..308
        fsync = 1'b1; @(negedge clk); fsync = 1'b0;
        repeat (299) @(negedge clk);                           // at count 300
        check(rx_en === 1'b0, "R8 pre-restart rx low at count 300", int'(rx_en), 0);
        fsync = 1'b1; @(negedge clk); fsync = 1'b0;            // count 1 again
        check(tx_en === 1'b0, "R8 tx window of old frame not reached", int'(tx_en), 0);
        repeat (4) @(negedge clk);                             // count 5
        check(rx_en === 1'b1, "R8 rx opens at count 5 after restart", int'(rx_en), 1);
        check(tx_win_n === 1'b1, "R6 indicator high outside tx window", int'(tx_win_n), 1);
        repeat (3) @(negedge clk);                             // count 8
        check(rx_en === 1'b0, "R2 rx closes after 3 counts", int'(rx_en), 0);
        repeat (293) @(negedge clk);                           // count 301
        check(tx_en === 1'b1 && tx_win_n === 1'b0, "R3 R6 tx slot 0 open", int'(tx_en), 1);
        tx_ind_en = 1'b0;
        #1;
        check(tx_win_n === 1'b1, "R6 indicator disabled stays high", int'(tx_win_n), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule